// File: doc/BRIEF.md
# Partially Decoded I/O Page Selector with Keyed Register Window

This block sits between a CPU address bus and one 4 KiB-aligned I/O page. It turns a 16-bit address and a read/not-write strobe into three chip selects: one for a video controller and one for each of two peripheral adapters. The decoding is deliberately partial. Each device appears at many aliases, and some addresses enable two or three devices at once. A read at such an address makes several devices drive the bus, so the block flags it. A write at such an address is harmless and simply reaches every selected device in the same cycle.

Inside the page there are address groups that no stock device decodes. The block places a private register window in those groups, but keeps it closed after reset. The window opens only after a fixed three-byte key has been written to the top video register at 0x900F. Once open, one group strobes a palette register file and another strobes an EEPROM command/data port. The remaining groups read back as zero. A single zero byte written to 0x900F closes the window again.

The block also drives the enable of its own data-bus driver. It enables that driver only for the sixteen base video registers and, while the window is open, for the undecoded groups. It never enables it where an adapter could also be driving the bus.

Top module: `io_page_decoder`

## Requirements
- R1: `vid_sel_o` is 1 exactly when addr_i[15:8] = 0x90, whatever the other address bits, rnw_i or valid_i are.
- R2: `pa1_sel_o` is 1 exactly when addr_i[15:10] = 6'b100100 and addr_i[4] = 1.
- R3: `pa2_sel_o` is 1 exactly when addr_i[15:10] = 6'b100100 and addr_i[5] = 1.
- R4: `collision_o` is 1 exactly when rnw_i = 1 (read) and at least two of the three selects are 1 (for example, a read at 0x903F).
- R5: For a write (rnw_i = 0) at an address that selects both adapters, both adapter selects are 1 in that cycle and `collision_o` is 0.
- R6: When valid_i = 1 and rnw_i = 1, `drive_en_o` is 1 for addresses 0x9000–0x900F, and `rdata_o` then equals `vid_rdata_i`. `drive_en_o` is never 1 while an adapter select is 1. `rdata_o` is 0x00 whenever `drive_en_o` is 0.
- R7: A hole is an address with addr_i[15:10] = 6'b100100, addr_i[9:8] != 00 and addr_i[5:4] = 00. While `unlocked_o` is 0, a hole gets no `drive_en_o`, no `pal_stb_o` and no `eep_stb_o`.
- R8: After three valid writes to 0x900F of 0xA5, 0x5A and 0xC3, in that order and counting only writes to 0x900F, `unlocked_o` is 1 from the clock edge that takes the third write. Any other value written to 0x900F restarts the match. A value of 0xA5 written while matching counts as the first key byte of a new attempt.
- R9: Once unlocked, the window stays open on any write to 0x900F except 0x00. A valid write of 0x00 to 0x900F, or an active-low reset on rst_ni, makes `unlocked_o` 0.
- R10: While unlocked, a valid access to group 0x910x (addr_i[9:6] = 4'b0100 in a hole) raises `pal_stb_o`. `reg_idx_o` always equals addr_i[3:0]. A read there drives `pal_rdata_i` onto `rdata_o` with `drive_en_o` = 1.
- R11: While unlocked, a valid access to group 0x914x (addr_i[9:6] = 4'b0101 in a hole) raises `eep_stb_o`. A read there drives `eep_rdata_i` onto `rdata_o` with `drive_en_o` = 1.
- R12: While unlocked, a read of any other hole group has `drive_en_o` = 1 and `rdata_o` = 0x00, with no strobe raised.
- R13: Writes with valid_i = 0, and writes to any address other than 0x900F (including its aliases such as 0x901F), leave the key matcher unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the key matcher updates on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low; closes the window |
| addr_i | input | 16 | CPU address |
| rnw_i | input | 1 | 1 = read, 0 = write |
| valid_i | input | 1 | Qualifies the current bus cycle |
| wdata_i | input | 8 | CPU write data |
| vid_rdata_i | input | 8 | Read data from the video controller |
| pal_rdata_i | input | 8 | Read data from the palette register file |
| eep_rdata_i | input | 8 | Read data from the EEPROM port |
| vid_sel_o | output | 1 | Video controller select |
| pa1_sel_o | output | 1 | First adapter select |
| pa2_sel_o | output | 1 | Second adapter select |
| collision_o | output | 1 | Read with more than one select active |
| drive_en_o | output | 1 | Output enable for this block's data-bus driver |
| rdata_o | output | 8 | Data for this block's driver |
| pal_stb_o | output | 1 | Palette register access strobe |
| eep_stb_o | output | 1 | EEPROM command/data strobe |
| reg_idx_o | output | 4 | Register index within the selected group |
| unlocked_o | output | 1 | Window open status |

## Verification
Two functions can fall in the same cycle. The first pair is the video select and the key matcher, because a key byte written to 0x900F also selects the video controller. The bench therefore sweeps all 65,536 addresses in both directions once with the window closed and once with it open. The opening writes themselves are judged through `unlocked_o` on the following negative edge. The second pair is the adapter overlap and the collision flag: the same sweep covers every address where both adapters are selected. Each such address must give a clean dual select on a write and a raised flag on a read.

// File: rtl/io_dec_pkg.sv
package io_dec_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_K1,
    ST_K2,
    ST_OPEN
  } key_st_e;

  typedef struct packed {
    logic       vid;
    logic       pa1;
    logic       pa2;
    logic       vid_base;
    logic       hole;
    logic [3:0] grp;
    logic [3:0] idx;
  } dec_t;

endpackage

// File: rtl/io_addr_decode.sv
module io_addr_decode
  import io_dec_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter logic [7:0]  PAGE_HI  = 8'h90,
  parameter logic [5:0]  PAGE_TOP = 6'b100100
) (
  input  logic [ADDR_W-1:0] addr_i,
  output dec_t              dec_o
);

  logic page_hit;

  assign page_hit = (addr_i[15:10] == PAGE_TOP);

  always_comb begin
    dec_o          = '0;
    dec_o.vid      = (addr_i[15:8] == PAGE_HI);
    dec_o.pa1      = page_hit & addr_i[4];
    dec_o.pa2      = page_hit & addr_i[5];
    dec_o.vid_base = (addr_i[15:8] == PAGE_HI) & (addr_i[7:4] == 4'h0);
    // undecoded hole: adapter bits clear, outside the video slice
    dec_o.hole     = page_hit & (addr_i[9:8] != 2'b00) & (addr_i[5:4] == 2'b00);
    dec_o.grp      = addr_i[9:6];
    dec_o.idx      = addr_i[3:0];
  end

endmodule

// File: rtl/io_unlock_fsm.sv
module io_unlock_fsm
  import io_dec_pkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-1:0] KEY0     = 8'hA5,
  parameter logic [DATA_W-1:0] KEY1     = 8'h5A,
  parameter logic [DATA_W-1:0] KEY2     = 8'hC3,
  parameter logic [DATA_W-1:0] LOCK_VAL = 8'h00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              key_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              open_o
);

  key_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (key_wr_i) begin
      if (wdata_i == LOCK_VAL) begin
        st_d = ST_IDLE;
      end else begin
        unique case (st_q)
          ST_OPEN: st_d = ST_OPEN;
          ST_K2:   st_d = (wdata_i == KEY2) ? ST_OPEN :
                          (wdata_i == KEY0) ? ST_K1 : ST_IDLE;
          ST_K1:   st_d = (wdata_i == KEY1) ? ST_K2 :
                          (wdata_i == KEY0) ? ST_K1 : ST_IDLE;
          default: st_d = (wdata_i == KEY0) ? ST_K1 : ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign open_o = (st_q == ST_OPEN);

  AST_OPEN_ONLY_ON_KEY2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_o) |-> $past(key_wr_i && (wdata_i == KEY2))); // R8

  AST_LOCK_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_wr_i && (wdata_i == LOCK_VAL)) |=> !open_o); // R9

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !key_wr_i |=> $stable(open_o)); // R13

endmodule

// File: rtl/io_window_map.sv
module io_window_map
  import io_dec_pkg::*;
#(
  parameter int         DATA_W  = 8,
  parameter logic [3:0] PAL_GRP = 4'b0100,
  parameter logic [3:0] EEP_GRP = 4'b0101
) (
  input  dec_t              dec_i,
  input  logic              unlocked_i,
  input  logic              valid_i,
  input  logic              rnw_i,
  input  logic [DATA_W-1:0] vid_rdata_i,
  input  logic [DATA_W-1:0] pal_rdata_i,
  input  logic [DATA_W-1:0] eep_rdata_i,
  output logic              drive_en_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              pal_stb_o,
  output logic              eep_stb_o
);

  logic pal_hit, eep_hit, win_hit;

  assign win_hit = dec_i.hole & unlocked_i;
  assign pal_hit = win_hit & (dec_i.grp == PAL_GRP);
  assign eep_hit = win_hit & (dec_i.grp == EEP_GRP);

  assign pal_stb_o  = valid_i & pal_hit;
  assign eep_stb_o  = valid_i & eep_hit;
  assign drive_en_o = valid_i & rnw_i & (dec_i.vid_base | win_hit);

  always_comb begin
    rdata_o = '0;
    if (drive_en_o) begin
      if (dec_i.vid_base)  rdata_o = vid_rdata_i;
      else if (pal_hit)    rdata_o = pal_rdata_i;
      else if (eep_hit)    rdata_o = eep_rdata_i;
      // reserved groups read as zero
    end
  end

endmodule

// File: rtl/io_page_decoder.sv
module io_page_decoder
  import io_dec_pkg::*;
#(
  parameter int                DATA_W      = 8,
  parameter logic [15:0]       UNLOCK_ADDR = 16'h900F,
  parameter logic [DATA_W-1:0] KEY0        = 8'hA5,
  parameter logic [DATA_W-1:0] KEY1        = 8'h5A,
  parameter logic [DATA_W-1:0] KEY2        = 8'hC3,
  parameter logic [DATA_W-1:0] LOCK_VAL    = 8'h00,
  parameter logic [3:0]        PAL_GRP     = 4'b0100,
  parameter logic [3:0]        EEP_GRP     = 4'b0101
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       addr_i,
  input  logic              rnw_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] vid_rdata_i,
  input  logic [DATA_W-1:0] pal_rdata_i,
  input  logic [DATA_W-1:0] eep_rdata_i,
  output logic              vid_sel_o,
  output logic              pa1_sel_o,
  output logic              pa2_sel_o,
  output logic              collision_o,
  output logic              drive_en_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              pal_stb_o,
  output logic              eep_stb_o,
  output logic [3:0]        reg_idx_o,
  output logic              unlocked_o
);

  localparam int ADDR_W = 16;

  dec_t       dec;
  logic       key_wr;
  logic [1:0] sel_cnt;

  io_addr_decode #(.ADDR_W(ADDR_W)) i_dec (
    .addr_i (addr_i),
    .dec_o  (dec)
  );

  assign key_wr = valid_i & ~rnw_i & (addr_i == UNLOCK_ADDR);

  io_unlock_fsm #(
    .DATA_W   (DATA_W),
    .KEY0     (KEY0),
    .KEY1     (KEY1),
    .KEY2     (KEY2),
    .LOCK_VAL (LOCK_VAL)
  ) i_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .key_wr_i (key_wr),
    .wdata_i  (wdata_i),
    .open_o   (unlocked_o)
  );

  io_window_map #(
    .DATA_W  (DATA_W),
    .PAL_GRP (PAL_GRP),
    .EEP_GRP (EEP_GRP)
  ) i_win (
    .dec_i       (dec),
    .unlocked_i  (unlocked_o),
    .valid_i     (valid_i),
    .rnw_i       (rnw_i),
    .vid_rdata_i (vid_rdata_i),
    .pal_rdata_i (pal_rdata_i),
    .eep_rdata_i (eep_rdata_i),
    .drive_en_o  (drive_en_o),
    .rdata_o     (rdata_o),
    .pal_stb_o   (pal_stb_o),
    .eep_stb_o   (eep_stb_o)
  );

  assign vid_sel_o = dec.vid;
  assign pa1_sel_o = dec.pa1;
  assign pa2_sel_o = dec.pa2;
  assign reg_idx_o = dec.idx;

  assign sel_cnt     = {1'b0, dec.vid} + {1'b0, dec.pa1} + {1'b0, dec.pa2};
  assign collision_o = rnw_i & (sel_cnt > 2'd1);

  AST_DUAL_WRITE_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rnw_i && pa1_sel_o && pa2_sel_o) |-> !collision_o); // R5

  AST_DRIVE_NOT_ADAPTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_en_o |-> !(pa1_sel_o || pa2_sel_o)); // R6

  AST_DRIVE_NO_COLLISION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_en_o |-> !collision_o); // R4

  AST_LOCKED_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlocked_o |-> (!pal_stb_o && !eep_stb_o)); // R7

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pal_stb_o, eep_stb_o, vid_sel_o})); // R10

endmodule

// File: tb/test_io_page_decoder.sv
module test_io_page_decoder;

  localparam time TCK = 8ns;
  localparam logic [7:0] VID_D = 8'h3C;
  localparam logic [7:0] PAL_D = 8'h96;
  localparam logic [7:0] EEP_D = 8'hE1;
  localparam int NF = 9;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr_i = '0;
  logic        rnw_i = 1'b1;
  logic        valid_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic        vid_sel_o, pa1_sel_o, pa2_sel_o, collision_o, drive_en_o;
  logic [7:0]  rdata_o;
  logic        pal_stb_o, eep_stb_o, unlocked_o;
  logic [3:0]  reg_idx_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(TCK/2) clk_i = ~clk_i;

  io_page_decoder i_io_page_decoder (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_i      (addr_i),
    .rnw_i       (rnw_i),
    .valid_i     (valid_i),
    .wdata_i     (wdata_i),
    .vid_rdata_i (VID_D),
    .pal_rdata_i (PAL_D),
    .eep_rdata_i (EEP_D),
    .vid_sel_o   (vid_sel_o),
    .pa1_sel_o   (pa1_sel_o),
    .pa2_sel_o   (pa2_sel_o),
    .collision_o (collision_o),
    .drive_en_o  (drive_en_o),
    .rdata_o     (rdata_o),
    .pal_stb_o   (pal_stb_o),
    .eep_stb_o   (eep_stb_o),
    .reg_idx_o   (reg_idx_o),
    .unlocked_o  (unlocked_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic v);
    @(negedge clk_i);
    addr_i = a; rnw_i = 1'b0; wdata_i = d; valid_i = v;
    @(negedge clk_i);
    valid_i = 1'b0; rnw_i = 1'b1; addr_i = 16'h0000; wdata_i = 8'h77;
  endtask

  task automatic sweep(input bit unl, input string phase);
    int          bad [NF];
    int          bact[NF];
    int          bexp[NF];
    int          act [NF];
    int          exp [NF];
    string       nm  [NF];
    nm[0] = "R1 vid_sel";   nm[1] = "R2 pa1_sel";  nm[2] = "R3 pa2_sel";
    nm[3] = "R4 R5 collision";
    nm[4] = unl ? "R6 R12 drive_en" : "R6 R7 drive_en";
    nm[5] = unl ? "R6 R10 R11 R12 rdata" : "R6 R7 rdata";
    nm[6] = unl ? "R10 pal_stb" : "R7 pal_stb";
    nm[7] = unl ? "R11 eep_stb" : "R7 eep_stb";
    nm[8] = "R10 reg_idx";
    for (int k = 0; k < NF; k++) bad[k] = 0;
    wdata_i = 8'h77;
    valid_i = 1'b1;
    for (int a = 0; a < 65536; a++) begin
      for (int r = 0; r < 2; r++) begin
        logic [15:0] ad;
        bit v, p1, p2, base, hole, pal, eep, drv;
        int rd;
        ad = a[15:0];
        addr_i = ad; rnw_i = r[0];
        #1;
        v    = (ad[15:8] == 8'h90);
        p1   = (ad[15:10] == 6'b100100) && ad[4];
        p2   = (ad[15:10] == 6'b100100) && ad[5];
        base = (ad[15:4] == 12'h900);
        hole = (ad[15:10] == 6'b100100) && (ad[9:8] != 2'b00) && (ad[5:4] == 2'b00);
        pal  = unl && hole && (ad[9:6] == 4'b0100);
        eep  = unl && hole && (ad[9:6] == 4'b0101);
        drv  = (r == 1) && (base || (unl && hole));
        rd   = !drv ? 0 : base ? int'(VID_D) : pal ? int'(PAL_D) : eep ? int'(EEP_D) : 0;
        exp[0] = v; exp[1] = p1; exp[2] = p2;
        exp[3] = (r == 1) && ((int'(v) + int'(p1) + int'(p2)) >= 2);
        exp[4] = drv; exp[5] = rd; exp[6] = pal; exp[7] = eep; exp[8] = int'(ad[3:0]);
        act[0] = vid_sel_o; act[1] = pa1_sel_o; act[2] = pa2_sel_o;
        act[3] = collision_o; act[4] = drive_en_o; act[5] = int'(rdata_o);
        act[6] = pal_stb_o; act[7] = eep_stb_o; act[8] = int'(reg_idx_o);
        for (int k = 0; k < NF; k++) begin
          if (act[k] != exp[k]) begin
            if (bad[k] == 0) begin bact[k] = act[k]; bexp[k] = exp[k]; end
            bad[k]++;
          end
        end
      end
    end
    valid_i = 1'b0; rnw_i = 1'b1; addr_i = 16'h0000;
    for (int k = 0; k < NF; k++)
      check(bad[k] == 0, {phase, " ", nm[k]}, bad[k] ? bact[k] : 0, bad[k] ? bexp[k] : 0);
  endtask

  initial begin
    #(TCK * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(unlocked_o == 1'b0, "R9 reset state unlocked_o", unlocked_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(unlocked_o == 1'b0, "R9 after reset release", unlocked_o, 0);

    sweep(1'b0, "locked");

    // specific dual-adapter write and triple read
    @(negedge clk_i);
    addr_i = 16'h9030; rnw_i = 1'b0; valid_i = 1'b1; wdata_i = 8'h12; #1;
    check(pa1_sel_o && pa2_sel_o && !collision_o, "R5 dual write 0x9030",
          {pa1_sel_o, pa2_sel_o, collision_o}, 3'b110);
    addr_i = 16'h903F; rnw_i = 1'b1; #1;
    check(collision_o == 1'b1, "R4 read 0x903F collision", collision_o, 1);
    valid_i = 1'b0; addr_i = 16'h0000;

    // basic unlock
    wr(16'h900F, 8'hA5, 1'b1);
    wr(16'h900F, 8'h5A, 1'b1);
    check(unlocked_o == 1'b0, "R8 not open after two keys", unlocked_o, 0);
    wr(16'h900F, 8'hC3, 1'b1);
    check(unlocked_o == 1'b1, "R8 open after key sequence", unlocked_o, 1);

    sweep(1'b1, "unlocked");

    wr(16'h900F, 8'h12, 1'b1);
    check(unlocked_o == 1'b1, "R9 nonzero write keeps open", unlocked_o, 1);
    wr(16'h900F, 8'hA5, 1'b1);
    check(unlocked_o == 1'b1, "R9 key byte keeps open", unlocked_o, 1);
    wr(16'h901F, 8'h00, 1'b1);
    check(unlocked_o == 1'b1, "R13 zero to alias 0x901F ignored", unlocked_o, 1);
    wr(16'h900F, 8'h00, 1'b0);
    check(unlocked_o == 1'b1, "R13 invalid zero write ignored", unlocked_o, 1);
    wr(16'h900F, 8'h00, 1'b1);
    check(unlocked_o == 1'b0, "R9 zero write closes", unlocked_o, 0);

    // locked hole: read undriven
    @(negedge clk_i);
    addr_i = 16'h9105; rnw_i = 1'b1; valid_i = 1'b1; #1;
    check(!drive_en_o && !pal_stb_o, "R7 relocked hole 0x9105 silent",
          {drive_en_o, pal_stb_o}, 0);
    valid_i = 1'b0; addr_i = 16'h0000;

    // restart: repeated first key counts
    wr(16'h900F, 8'hA5, 1'b1);
    wr(16'h900F, 8'hA5, 1'b1);
    wr(16'h900F, 8'h5A, 1'b1);
    wr(16'h900F, 8'hC3, 1'b1);
    check(unlocked_o == 1'b1, "R8 A5 A5 5A C3 opens", unlocked_o, 1);
    wr(16'h900F, 8'h00, 1'b1);

    // wrong middle byte breaks the match
    wr(16'h900F, 8'hA5, 1'b1);
    wr(16'h900F, 8'h5A, 1'b1);
    wr(16'h900F, 8'h11, 1'b1);
    wr(16'h900F, 8'hC3, 1'b1);
    check(unlocked_o == 1'b0, "R8 broken sequence stays closed", unlocked_o, 0);

    // A5 after 5A restarts
    wr(16'h900F, 8'hA5, 1'b1);
    wr(16'h900F, 8'h5A, 1'b1);
    wr(16'h900F, 8'hA5, 1'b1);
    wr(16'h900F, 8'hC3, 1'b1);
    check(unlocked_o == 1'b0, "R8 A5 5A A5 C3 stays closed", unlocked_o, 0);

    // intervening writes elsewhere and invalid cycles ignored
    wr(16'h900F, 8'hA5, 1'b1);
    wr(16'h901F, 8'h33, 1'b1);
    wr(16'h900E, 8'h44, 1'b1);
    wr(16'h900F, 8'h5A, 1'b1);
    wr(16'h900F, 8'h99, 1'b0);
    wr(16'h900F, 8'hC3, 1'b1);
    check(unlocked_o == 1'b1, "R13 unrelated writes skip matcher", unlocked_o, 1);

    // palette write strobe
    @(negedge clk_i);
    addr_i = 16'h910A; rnw_i = 1'b0; valid_i = 1'b1; #1;
    check(pal_stb_o && !drive_en_o && reg_idx_o == 4'hA, "R10 palette write strobe",
          {pal_stb_o, drive_en_o, reg_idx_o}, {1'b1, 1'b0, 4'hA});
    addr_i = 16'h9143; #1;
    check(eep_stb_o && !pal_stb_o, "R11 eeprom write strobe", {eep_stb_o, pal_stb_o}, 2'b10);
    valid_i = 1'b0; #1;
    check(!eep_stb_o && !pal_stb_o, "R13 no strobe without valid", {eep_stb_o, pal_stb_o}, 0);
    addr_i = 16'h0000; rnw_i = 1'b1;

    // reset closes window
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check(unlocked_o == 1'b0, "R9 reset closes window", unlocked_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule